// File: doc/BRIEF.md
# Synchronous Burst Read Engine

This block is the device side of a clocked burst-read port for a memory organised as 16-bit words. The host puts a start address on the bus with chip enable high and drops the active-low address strobe. On that rising edge the engine captures the address and the current configuration. It then waits a programmable number of clocks and after that returns one word per clock, with a ready flag that marks each valid word. The words come from a small internal RAM, which a dedicated load port fills before reads begin.

A 5-bit configuration word sets three things: the initial latency, whether the burst runs linearly through the whole array or circles inside an aligned group of eight words, and whether ready is driven at all. In linear mode the engine inserts one idle cycle each time the address moves into a new 64-word block. In group mode the burst has no such stall and never stops by itself. A burst ends only on reset or when a new address is captured. While chip enable or output enable is low, the data bus rests at a fixed idle word and ready stays low.

Top module: `burst_read_engine`

## Requirements
- R1: The engine captures `addr` on a rising edge only when `chip_en` is 1 and `addr_strobe_n` is 0. With `chip_en` at 0, a low strobe is ignored and any burst in progress continues unchanged.
- R2: `cfg_wdata` bits [2:0] hold the latency field, bit 3 selects group mode (1) or linear mode (0), and bit 4 enables ready (1). The field is loaded when `cfg_we` is high at a clock edge. The first word appears on the outputs after exactly L edges counted from the capture edge, where L is the field value and values 0 and 1 are treated as 2. Before that word, the bus shows the idle word.
- R3: In linear mode each following word comes one clock after the previous one, from the address one higher. After address 255 the address rolls over to 0.
- R4: In linear mode, whenever the next address has its low 6 bits equal to zero, one extra cycle with ready low and the idle word on the bus comes before that word. The first word of a burst never stalls.
- R5: In group mode the words run in ascending order inside the aligned 8-word group and wrap from the top word to the bottom one (6, 7, 0, 1, ...). This continues with no stall cycles and no end.
- R6: Capturing a new address during a burst abandons the old burst. The new latency count then starts.
- R7: `ready` is 1 only during a valid word and only while the ready-enable bit is set. With the bit clear, the data still appears but `ready` stays 0.
- R8: While `chip_en` or `out_en` is 0, `dout` equals the idle word (all zeros by default) and `ready` is 0. The burst sequence keeps advancing underneath.
- R9: After a synchronous reset the bus holds the idle word and `ready` is 0. The configuration is latency 7, linear mode and ready disabled.
- R10: A write on the load port (`ld_we`, `ld_addr`, `ld_data`) at a clock edge stores the word that later bursts read from that address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| chip_en | input | 1 | Chip enable, active high |
| addr_strobe_n | input | 1 | Address strobe, active low |
| out_en | input | 1 | Output enable, active high |
| addr | input | 8 | Burst start address |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 5 | Configuration word: [4] ready enable, [3] group mode, [2:0] latency |
| ld_we | input | 1 | Array load write enable |
| ld_addr | input | 8 | Array load address |
| ld_data | input | 16 | Array load data |
| dout | output | 16 | Read data, or the idle word when nothing is valid |
| ready | output | 1 | High while `dout` carries a valid word |

## Verification
The bench counts edges from the one that captures the address. Observation slot j, taken at the falling edge that follows capture edge + j, shows the idle word for j < L. The first word arrives in slot L, and each later word one slot after the previous one, with an added idle slot before each linear 64-word crossing. The driver stamps every expected item with its absolute cycle number. The monitor compares an item only when that cycle is reached. Enable gaps are driven half a cycle before the slot they mask, so each comparison falls in a cycle with no input changing.

// File: rtl/brs_pkg.sv
`timescale 1ns/1ps
package brs_pkg;

    localparam int unsigned LAT_W   = 3;
    localparam int unsigned CFG_W   = LAT_W + 2;
    localparam logic [LAT_W-1:0] LAT_MIN = 3'd2;

    // Configuration word: [4] ready enable, [3] group mode, [2:0] latency
    typedef struct packed {
        logic             rdy_en;
        logic             grp_mode;
        logic [LAT_W-1:0] lat;
    } brs_cfg_t;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_WAIT  = 2'd1,
        ST_BURST = 2'd2,
        ST_STALL = 2'd3
    } brs_state_e;

    localparam brs_cfg_t CFG_RESET = '{rdy_en: 1'b0, grp_mode: 1'b0, lat: 3'd7};

    // Latency below the legal floor is raised to it; the field width caps it at 7.
    function automatic logic [LAT_W-1:0] clamp_lat(input logic [LAT_W-1:0] raw);
        return (raw < LAT_MIN) ? LAT_MIN : raw;
    endfunction

endpackage

// File: rtl/brs_cfg_reg.sv
`timescale 1ns/1ps
module brs_cfg_reg
    import brs_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [CFG_W-1:0] wdata,
    output brs_cfg_t         cfg
);

    brs_cfg_t wr_cfg;

    always_comb begin
        wr_cfg     = brs_cfg_t'(wdata);
        wr_cfg.lat = clamp_lat(wr_cfg.lat);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg <= CFG_RESET;
        end else if (we) begin
            cfg <= wr_cfg;
        end
    end

endmodule

// File: rtl/brs_array.sv
`timescale 1ns/1ps
module brs_array #(
    parameter int unsigned ADDR_W = 8,
    parameter int unsigned DATA_W = 16
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);

    localparam int unsigned DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata = mem[raddr];

endmodule

// File: rtl/brs_addr_gen.sv
`timescale 1ns/1ps
module brs_addr_gen #(
    parameter int unsigned ADDR_W  = 8,
    parameter int unsigned GROUP_W = 3,
    parameter int unsigned BLOCK_W = 6
) (
    input  logic [ADDR_W-1:0] cur,
    input  logic              grp_mode,
    output logic [ADDR_W-1:0] next,
    output logic              at_block_edge
);

    localparam int unsigned HI_W = ADDR_W - GROUP_W;

    logic [ADDR_W-1:0]  lin_next;
    logic [ADDR_W-1:0]  grp_next;
    logic [GROUP_W-1:0] grp_low;

    assign lin_next = cur + 1'b1;
    assign grp_low  = cur[GROUP_W-1:0] + 1'b1;

    generate
        if (HI_W > 0) begin : g_hi
            assign grp_next = {cur[ADDR_W-1:GROUP_W], grp_low};
        end else begin : g_flat
            assign grp_next = grp_low;
        end
    endgenerate

    assign next          = grp_mode ? grp_next : lin_next;
    assign at_block_edge = !grp_mode && (cur[BLOCK_W-1:0] == '0);

endmodule

// File: rtl/brs_ctrl.sv
`timescale 1ns/1ps
module brs_ctrl
    import brs_pkg::*;
#(
    parameter int unsigned ADDR_W = 8,
    parameter int unsigned DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              capture,
    input  logic [ADDR_W-1:0] start_addr,
    input  brs_cfg_t          cfg,
    input  logic [DATA_W-1:0] rdata,
    input  logic [ADDR_W-1:0] next_addr,
    input  logic              at_block_edge,
    output logic [ADDR_W-1:0] cur_addr,
    output logic              grp_mode_q,
    output brs_state_e        state,
    output logic [DATA_W-1:0] data_q,
    output logic              valid_q
);

    logic [LAT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= ST_IDLE;
            cnt        <= '0;
            cur_addr   <= '0;
            grp_mode_q <= 1'b0;
            data_q     <= '0;
            valid_q    <= 1'b0;
        end else if (capture) begin
            state      <= ST_WAIT;
            cnt        <= cfg.lat - 1'b1;
            cur_addr   <= start_addr;
            grp_mode_q <= cfg.grp_mode;
            valid_q    <= 1'b0;
        end else begin
            unique case (state)
                ST_WAIT: begin
                    if (cnt == '0) begin
                        data_q   <= rdata;
                        valid_q  <= 1'b1;
                        cur_addr <= next_addr;
                        state    <= ST_BURST;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                ST_BURST: begin
                    if (at_block_edge) begin
                        valid_q <= 1'b0;
                        state   <= ST_STALL;
                    end else begin
                        data_q   <= rdata;
                        cur_addr <= next_addr;
                    end
                end
                ST_STALL: begin
                    data_q   <= rdata;
                    valid_q  <= 1'b1;
                    cur_addr <= next_addr;
                    state    <= ST_BURST;
                end
                default: begin
                    valid_q <= 1'b0;
                end
            endcase
        end
    end

endmodule

// File: rtl/burst_read_engine.sv
`timescale 1ns/1ps
module burst_read_engine
    import brs_pkg::*;
#(
    parameter int unsigned          ADDR_W    = 8,
    parameter int unsigned          DATA_W    = 16,
    parameter int unsigned          GROUP_W   = 3,
    parameter int unsigned          BLOCK_W   = 6,
    parameter logic [DATA_W-1:0]    IDLE_WORD = '0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              chip_en,
    input  logic              addr_strobe_n,
    input  logic              out_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic              cfg_we,
    input  logic [CFG_W-1:0]  cfg_wdata,
    input  logic              ld_we,
    input  logic [ADDR_W-1:0] ld_addr,
    input  logic [DATA_W-1:0] ld_data,
    output logic [DATA_W-1:0] dout,
    output logic              ready
);

    brs_cfg_t          cfg_q;
    brs_state_e        state_w;
    logic              capture_w;
    logic              bus_on_w;
    logic              valid_w;
    logic              grp_w;
    logic              edge_w;
    logic [ADDR_W-1:0] cur_w;
    logic [ADDR_W-1:0] next_w;
    logic [DATA_W-1:0] rdata_w;
    logic [DATA_W-1:0] data_w;

    assign capture_w = chip_en && !addr_strobe_n;
    assign bus_on_w  = chip_en && out_en;

    brs_cfg_reg u_cfg (
        .clk   (clk),
        .rst   (rst),
        .we    (cfg_we),
        .wdata (cfg_wdata),
        .cfg   (cfg_q)
    );

    brs_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_array (
        .clk   (clk),
        .we    (ld_we),
        .waddr (ld_addr),
        .wdata (ld_data),
        .raddr (cur_w),
        .rdata (rdata_w)
    );

    brs_addr_gen #(.ADDR_W(ADDR_W), .GROUP_W(GROUP_W), .BLOCK_W(BLOCK_W)) u_agen (
        .cur           (cur_w),
        .grp_mode      (grp_w),
        .next          (next_w),
        .at_block_edge (edge_w)
    );

    brs_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ctrl (
        .clk           (clk),
        .rst           (rst),
        .capture       (capture_w),
        .start_addr    (addr),
        .cfg           (cfg_q),
        .rdata         (rdata_w),
        .next_addr     (next_w),
        .at_block_edge (edge_w),
        .cur_addr      (cur_w),
        .grp_mode_q    (grp_w),
        .state         (state_w),
        .data_q        (data_w),
        .valid_q       (valid_w)
    );

    assign dout  = (bus_on_w && valid_w) ? data_w : IDLE_WORD;
    assign ready = bus_on_w && valid_w && cfg_q.rdy_en;

endmodule

// File: rtl/brs_checker.sv
`timescale 1ns/1ps
module brs_checker
    import brs_pkg::*;
#(
    parameter int unsigned       ADDR_W    = 8,
    parameter int unsigned       DATA_W    = 16,
    parameter int unsigned       GROUP_W   = 3,
    parameter int unsigned       BLOCK_W   = 6,
    parameter logic [DATA_W-1:0] IDLE_WORD = '0
) (
    input logic              clk,
    input logic              rst,
    input logic              chip_en,
    input logic              addr_strobe_n,
    input logic              out_en,
    input logic [DATA_W-1:0] dout,
    input logic              ready,
    input brs_cfg_t          cfg_q,
    input brs_state_e        state_w,
    input logic              valid_w,
    input logic              grp_w,
    input logic [ADDR_W-1:0] cur_w
);

    logic cap;
    assign cap = chip_en && !addr_strobe_n;

    p_capture_hides_word_r1: assert property (@(posedge clk) disable iff (rst)
        cap |=> !valid_w);

    p_min_latency_r2: assert property (@(posedge clk) disable iff (rst)
        cap |=> !valid_w ##1 !valid_w);

    p_latency_floor_r2: assert property (@(posedge clk) disable iff (rst)
        cfg_q.lat >= LAT_MIN);

    p_linear_step_r3: assert property (@(posedge clk) disable iff (rst)
        (state_w == ST_BURST && !grp_w && !cap && cur_w[BLOCK_W-1:0] != '0)
        |=> cur_w == ADDR_W'($past(cur_w) + 1'b1));

    p_block_stall_r4: assert property (@(posedge clk) disable iff (rst)
        (state_w == ST_BURST && !grp_w && !cap && cur_w[BLOCK_W-1:0] == '0)
        |=> !valid_w && !ready);

    p_group_stays_r5: assert property (@(posedge clk) disable iff (rst)
        (state_w == ST_BURST && grp_w && !cap)
        |=> $stable(cur_w[ADDR_W-1:GROUP_W]) && valid_w);

    p_ready_needs_enable_r7: assert property (@(posedge clk) disable iff (rst)
        ready |-> cfg_q.rdy_en);

    p_idle_bus_r8: assert property (@(posedge clk) disable iff (rst)
        (!chip_en || !out_en) |-> (dout == IDLE_WORD && !ready));

endmodule

bind burst_read_engine brs_checker #(
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W),
    .GROUP_W   (GROUP_W),
    .BLOCK_W   (BLOCK_W),
    .IDLE_WORD (IDLE_WORD)
) u_brs_chk (
    .clk           (clk),
    .rst           (rst),
    .chip_en       (chip_en),
    .addr_strobe_n (addr_strobe_n),
    .out_en        (out_en),
    .dout          (dout),
    .ready         (ready),
    .cfg_q         (cfg_q),
    .state_w       (state_w),
    .valid_w       (valid_w),
    .grp_w         (grp_w),
    .cur_w         (cur_w)
);

// File: tb/burst_read_engine_tb_top.sv
`timescale 1ns/1ps
module burst_read_engine_tb_top;

    localparam int CLK_NS = 4;
    localparam logic [15:0] IDLE = 16'h0000;

    typedef struct {
        int          cyc;
        logic [15:0] d;
        logic        r;
        string       tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        chip_en = 1'b0;
    logic        addr_strobe_n = 1'b1;
    logic        out_en = 1'b1;
    logic [7:0]  addr = '0;
    logic        cfg_we = 1'b0;
    logic [4:0]  cfg_wdata = '0;
    logic        ld_we = 1'b0;
    logic [7:0]  ld_addr = '0;
    logic [15:0] ld_data = '0;
    logic [15:0] dout;
    logic        ready;

    int   cyc = 0;
    int   n_checks = 0;
    int   n_errors = 0;
    exp_t q[$];

    burst_read_engine dut_i (
        .clk           (clk),
        .rst           (rst),
        .chip_en       (chip_en),
        .addr_strobe_n (addr_strobe_n),
        .out_en        (out_en),
        .addr          (addr),
        .cfg_we        (cfg_we),
        .cfg_wdata     (cfg_wdata),
        .ld_we         (ld_we),
        .ld_addr       (ld_addr),
        .ld_data       (ld_data),
        .dout          (dout),
        .ready         (ready)
    );

    always #(CLK_NS / 2) clk = ~clk;

    initial forever begin
        @(posedge clk);
        cyc++;
    end

    function automatic logic [15:0] word_at(input int a);
        return 16'((a * 16'h0123) ^ 16'h5A5A);
    endfunction

    task automatic check(input string tag, input logic [15:0] gd, input logic [15:0] ed,
                         input logic gr, input logic er);
        n_checks++;
        if (gd !== ed || gr !== er) begin
            n_errors++;
            $display("FAIL %s cyc=%0d dout=%h exp=%h ready=%b exp=%b", tag, cyc, gd, ed, gr, er);
        end
    endtask

    // Monitor: compare each expected item in the cycle it is stamped for
    initial forever begin
        @(negedge clk);
        while (q.size() > 0 && q[0].cyc < cyc) begin
            exp_t m;
            m = q.pop_front();
            n_checks++;
            n_errors++;
            $display("FAIL %s missed item cyc=%0d actual=none expected=%h", m.tag, m.cyc, m.d);
        end
        if (q.size() > 0 && q[0].cyc == cyc) begin
            exp_t e;
            e = q.pop_front();
            check(e.tag, dout, e.d, ready, e.r);
        end
    end

    task automatic write_cfg(input bit rdy, input bit grp, input int lat);
        @(negedge clk); #1;
        cfg_we    = 1'b1;
        cfg_wdata = {rdy, grp, 3'(lat)};
        @(negedge clk); #1;
        cfg_we = 1'b0;
    endtask

    // Driver: captures an address and pushes every expected slot.
    // gap_kind 1: chip enable low with a low strobe; 2: output enable low.
    task automatic run_burst(input int start, input int lat, input bit grp, input bit rdy,
                             input int nwords, input int gap_j, input int gap_kind,
                             input string tag);
        int n;
        int j;
        int a;
        exp_t e;
        @(negedge clk); #1;
        addr          = 8'(start);
        addr_strobe_n = 1'b0;
        chip_en       = 1'b1;
        n             = cyc;
        j             = 0;
        for (int k = 0; k < lat; k++) begin
            e = '{cyc: n + 1 + j, d: IDLE, r: 1'b0, tag: tag};
            q.push_back(e);
            j++;
        end
        a = start;
        for (int w = 0; w < nwords; w++) begin
            if (w > 0) begin
                a = grp ? ((a & ~7) | ((a + 1) & 7)) : ((a + 1) % 256);
                if (!grp && (a % 64) == 0) begin
                    e = '{cyc: n + 1 + j, d: IDLE, r: 1'b0, tag: tag};
                    q.push_back(e);
                    j++;
                end
            end
            e = '{cyc: n + 1 + j, d: word_at(a), r: rdy, tag: tag};
            if (j == gap_j) begin
                e.d = IDLE;
                e.r = 1'b0;
            end
            q.push_back(e);
            j++;
        end
        @(negedge clk); #1;
        addr_strobe_n = 1'b1;
        if (gap_j >= 0) begin
            while (cyc < n + gap_j) @(negedge clk);
            #1;
            if (gap_kind == 1) begin
                chip_en       = 1'b0;
                addr_strobe_n = 1'b0;
                addr          = 8'hAA;
            end else begin
                out_en = 1'b0;
            end
            @(negedge clk); #1;
            chip_en       = 1'b1;
            out_en        = 1'b1;
            addr_strobe_n = 1'b1;
        end
        while (cyc < n + j) @(negedge clk);
    endtask

    initial begin
        repeat (5) @(posedge clk);
        @(negedge clk); #1;
        rst     = 1'b0;
        chip_en = 1'b1;
        @(negedge clk);
        check("R9 reset idle", dout, IDLE, ready, 1'b0);

        // R10: preload the array through the load port
        for (int i = 0; i < 256; i++) begin
            @(negedge clk); #1;
            ld_we   = 1'b1;
            ld_addr = 8'(i);
            ld_data = word_at(i);
        end
        @(negedge clk); #1;
        ld_we = 1'b0;

        // R9: reset configuration, latency 7, linear, ready disabled
        run_burst(5, 7, 1'b0, 1'b0, 4, -1, 0, "R9 default cfg R10");

        // R2: latency values and the floor
        write_cfg(1'b1, 1'b0, 2);
        run_burst(10, 2, 1'b0, 1'b1, 6, -1, 0, "R2 lat2 R3");
        write_cfg(1'b1, 1'b0, 0);
        run_burst(20, 2, 1'b0, 1'b1, 3, -1, 0, "R2 lat0 clamp");
        write_cfg(1'b1, 1'b0, 1);
        run_burst(40, 2, 1'b0, 1'b1, 3, -1, 0, "R2 lat1 clamp");
        write_cfg(1'b1, 1'b0, 5);
        run_burst(70, 5, 1'b0, 1'b1, 3, -1, 0, "R2 lat5");
        write_cfg(1'b1, 1'b0, 7);
        run_burst(90, 7, 1'b0, 1'b1, 3, -1, 0, "R2 lat7");

        // R4 / R3: block crossings and rollover
        write_cfg(1'b1, 1'b0, 3);
        run_burst(62, 3, 1'b0, 1'b1, 5, -1, 0, "R4 cross 64");
        run_burst(64, 3, 1'b0, 1'b1, 3, -1, 0, "R4 start on edge");
        run_burst(254, 3, 1'b0, 1'b1, 5, -1, 0, "R3 rollover R4");

        // R5: group mode wraps without stalls
        write_cfg(1'b1, 1'b1, 3);
        run_burst(6, 3, 1'b1, 1'b1, 12, -1, 0, "R5 group from 6");
        run_burst(60, 3, 1'b1, 1'b1, 10, -1, 0, "R5 group near edge");
        // R6: long group burst abandoned by a new capture
        run_burst(130, 3, 1'b1, 1'b1, 20, -1, 0, "R6 long group");
        run_burst(200, 3, 1'b1, 1'b1, 4, -1, 0, "R6 restart");

        // R1 / R8: enable gaps in a linear burst
        write_cfg(1'b1, 1'b0, 4);
        run_burst(100, 4, 1'b0, 1'b1, 10, 7, 1, "R1 strobe ignored R8");
        run_burst(150, 4, 1'b0, 1'b1, 8, 6, 2, "R8 out_en low");

        // R7: ready disabled, data still driven
        write_cfg(1'b0, 1'b0, 2);
        run_burst(30, 2, 1'b0, 1'b0, 4, -1, 0, "R7 ready off");

        repeat (3) @(negedge clk);
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog actual=running expected=done");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule